// File: doc/BRIEF.md
# Linked-List DMA Tag Walker

This block drives one DMA channel through a chain of 64-bit transfer tags held in quadword-addressed memory. Software writes a control word and a starting tag address while the walker is idle. If the start bit is set and the mode field selects chain operation, the walker requests the tag at the current tag address. It then decodes the tag's 3-bit type and passes one packet command to a separate data mover. The command holds a start address, a scratchpad flag and a quadword count. The walker waits for the mover to report completion, and then either fetches the next tag or ends the chain.

Each tag type decides two things. The first is where the packet's data comes from: either the quadwords directly behind the tag, or the address carried in the tag's upper word. The second is where the next tag lives: directly behind the data, at the address in the tag, or at an address taken from a two-entry return stack. On every fetch, the upper half of the tag's lower word is copied into the top half of the control word, and the tag's count goes into a count register. Addresses that carry the scratchpad flag wrap within the scratchpad instead of running into main memory. When a chain ends, the start bit is cleared and a one-cycle done pulse is produced. If the chain stopped because of a tag interrupt, an interrupt pulse is produced in the same cycle.

Top module: `dma_chain_walker`

## Requirements
- R1: A control write while idle stores the word and the tag address. A fetch begins only when bit 8 (start) is 1 and bits [3:2] (mode) equal 1 (chain). If the mode is anything else, the start bit is stored as 0 and nothing is fetched. A control write while a chain is running is ignored.
- R2: Every tag fetch loads bits [31:16] of the control word from bits [31:16] of the tag, and loads the count register from tag bits [15:0].
- R3: The tag layout is: count in bits [15:0], type in bits [30:28], interrupt flag in bit 31, address in bits [62:32], scratchpad flag in bit 63. Types 1, 2, 5, 6 and 7 send data that starts at the tag address plus 1, carrying the tag address's own scratchpad flag.
- R4: Types 0, 3 and 4 send data from the tag's address field, carrying the tag's scratchpad flag. After types 3 and 4, the next tag is at the tag address plus 1.
- R5: After type 1, the next tag is at tag address + 1 + count. After type 2, the next tag is at the tag's address field.
- R6: Types 7 and 0 end the chain once their packet completes. At the end of a chain, bit 8 of the control word reads 0 and the done output pulses for exactly one cycle.
- R7: Type 5 pushes tag address + 1 + count onto the return stack and jumps to the tag's address field. Type 6 pops the stack and uses the popped entry as the next tag address. Control bits [5:4] show the stack depth (0 to 2). A written depth of 3 is stored as 2.
- R8: A type 5 tag with 2 entries on the stack, or a type 6 tag with an empty stack, ends the chain at once. No packet is issued and the stack depth does not change.
- R9: When control bit 7 (tag interrupt enable) and tag bit 31 are both 1, the chain stops after that tag's packet completes, and the interrupt output pulses in the same cycle as done.
- R10: For any address whose scratchpad flag is set, the address and every increment of it are taken modulo 2^SPW. The upper bits read as 0.
- R11: A tag whose count is 0 issues no packet and goes straight on to its next-tag decision.
- R12: A tag request or packet command, once raised, holds its fields steady until it is accepted. The two are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control word to write |
| tadr_wdata | input | AW | Starting tag address |
| tadr_wspr | input | 1 | Scratchpad flag of the starting tag address |
| ctl_rdata | output | 32 | Control word, including the mirrored tag half and the stack depth |
| cnt_rdata | output | 16 | Count field of the last fetched tag |
| tag_req | output | 1 | Tag read request |
| tag_addr | output | AW | Address of the tag being requested |
| tag_spr | output | 1 | Scratchpad flag of the tag request |
| tag_ack | input | 1 | Tag read response valid |
| tag_data | input | 64 | Tag contents |
| pkt_valid | output | 1 | Packet command valid |
| pkt_ready | input | 1 | Data mover accepts the command |
| pkt_addr | output | AW | Packet start address |
| pkt_spr | output | 1 | Packet scratchpad flag |
| pkt_qwc | output | 16 | Packet quadword count |
| pkt_done | input | 1 | Data mover has finished the accepted packet |
| chain_done | output | 1 | One-cycle pulse when the chain ends |
| chain_irq | output | 1 | One-cycle pulse when the chain stopped on a tag interrupt |

## Verification
The end of a chain and the stop on a tag interrupt can both fire on the same completion edge. The clearest case is a terminating tag that also carries an interrupt request; a plain data tag with the interrupt flag set and interrupt enable on takes the same stopping path. The bench runs the data tag with interrupt enable both on and off. It checks that with the enable on, done and the interrupt pulse together after exactly one packet and one fetch. With the enable off, the walker ignores the flag and fetches the following tag.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [2:0] {
        TID_REFEND = 3'd0,
        TID_INLINE = 3'd1,
        TID_JUMP   = 3'd2,
        TID_REF    = 3'd3,
        TID_REFSTL = 3'd4,
        TID_CALL   = 3'd5,
        TID_RET    = 3'd6,
        TID_END    = 3'd7
    } tag_id_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } walk_st_e;

    localparam logic [1:0] MODE_CHAIN = 2'd1;
    localparam int         BIT_START  = 8;
    localparam int         BIT_TIE    = 7;

endpackage

// File: rtl/dcw_addr_step.sv
module dcw_addr_step #(
    parameter int AW  = 31,
    parameter int SPW = 10
) (
    input  logic [AW-1:0] base,
    input  logic          spr,
    input  logic [16:0]   inc,
    output logic [AW-1:0] sum
);
    logic [AW-1:0]  full_sum;
    logic [SPW-1:0] wrap_sum;

    always_comb begin
        full_sum = base + AW'(inc);
        wrap_sum = base[SPW-1:0] + SPW'(inc);
        sum      = spr ? AW'(wrap_sum) : full_sum;
    end
endmodule

// File: rtl/dcw_addr_stack.sv
module dcw_addr_stack #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [1:0]   load_sp,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [1:0]   sp,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam logic [1:0] DMAX = 2'(DEPTH);

    logic [W-1:0] ent_q [DEPTH];
    logic [W-1:0] ent_d [DEPTH];
    logic [1:0]   sp_q, sp_d;

    assign sp    = sp_q;
    assign full  = (sp_q >= DMAX);
    assign empty = (sp_q == 2'd0);

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (2'(i + 1) == sp_q) top = ent_q[i];
        end
    end

    always_comb begin
        sp_d = sp_q;
        for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
        if (load) begin
            sp_d = (load_sp > DMAX) ? DMAX : load_sp;
        end else if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (2'(i) == sp_q) ent_d[i] = push_data;
            end
            sp_d = sp_q + 2'd1;
        end else if (pop && !empty) begin
            sp_d = sp_q - 2'd1;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ent_q[g] <= '0;
                else        ent_q[g] <= ent_d[g];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end
endmodule

// File: rtl/dcw_tag_decode.sv
module dcw_tag_decode
    import dcw_pkg::*;
#(
    parameter int AW  = 31,
    parameter int SPW = 10
) (
    input  logic [63:0]   tag,
    input  logic [AW-1:0] tadr,
    input  logic          tspr,
    input  logic [AW:0]   stk_top,
    input  logic          stk_full,
    input  logic          stk_empty,
    output logic [AW-1:0] pkt_addr,
    output logic          pkt_spr,
    output logic [15:0]   qwc,
    output logic [AW-1:0] next_tadr,
    output logic          next_spr,
    output logic          push,
    output logic          pop,
    output logic [AW:0]   push_data,
    output logic          fault,
    output logic          ends,
    output logic          irq_flag
);
    tag_id_e       id;
    logic          fld_spr;
    logic [AW-1:0] fld_addr;
    logic [AW-1:0] data_addr;
    logic [AW-1:0] after_addr;
    logic          unused_bits;

    assign id          = tag_id_e'(tag[30:28]);
    assign qwc         = tag[15:0];
    assign irq_flag    = tag[31];
    assign fld_spr     = tag[63];
    assign fld_addr    = fld_spr ? AW'(tag[32 +: SPW]) : tag[32 +: AW];
    assign unused_bits = ^{tag[27:16]};

    dcw_addr_step #(.AW(AW), .SPW(SPW)) u_data_step (
        .base(tadr), .spr(tspr), .inc(17'd1), .sum(data_addr)
    );

    dcw_addr_step #(.AW(AW), .SPW(SPW)) u_after_step (
        .base(tadr), .spr(tspr), .inc(17'(qwc) + 17'd1), .sum(after_addr)
    );

    always_comb begin
        pkt_addr  = data_addr;
        pkt_spr   = tspr;
        next_tadr = after_addr;
        next_spr  = tspr;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = {tspr, after_addr};
        fault     = 1'b0;
        ends      = 1'b0;
        case (id)
            TID_REFEND: begin
                pkt_addr  = fld_addr;
                pkt_spr   = fld_spr;
                next_tadr = data_addr;
                ends      = 1'b1;
            end
            TID_INLINE: begin
            end
            TID_JUMP: begin
                next_tadr = fld_addr;
                next_spr  = fld_spr;
            end
            TID_REF, TID_REFSTL: begin
                pkt_addr  = fld_addr;
                pkt_spr   = fld_spr;
                next_tadr = data_addr;
            end
            TID_CALL: begin
                next_tadr = fld_addr;
                next_spr  = fld_spr;
                fault     = stk_full;
                push      = !stk_full;
            end
            TID_RET: begin
                next_tadr = stk_top[AW-1:0];
                next_spr  = stk_top[AW];
                fault     = stk_empty;
                pop       = !stk_empty;
            end
            default: begin
                ends = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
    import dcw_pkg::*;
#(
    parameter int AW        = 31,
    parameter int SPW       = 10,
    parameter int STK_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [31:0]   ctl_wdata,
    input  logic [AW-1:0] tadr_wdata,
    input  logic          tadr_wspr,
    output logic [31:0]   ctl_rdata,
    output logic [15:0]   cnt_rdata,
    output logic          tag_req,
    output logic [AW-1:0] tag_addr,
    output logic          tag_spr,
    input  logic          tag_ack,
    input  logic [63:0]   tag_data,
    output logic          pkt_valid,
    input  logic          pkt_ready,
    output logic [AW-1:0] pkt_addr,
    output logic          pkt_spr,
    output logic [15:0]   pkt_qwc,
    input  logic          pkt_done,
    output logic          chain_done,
    output logic          chain_irq
);
    localparam int EW = AW + 1;

    typedef struct packed {
        walk_st_e      st;
        logic [31:0]   ctl;
        logic [15:0]   cnt;
        logic [AW-1:0] tadr;
        logic          tspr;
        logic [AW-1:0] paddr;
        logic          pspr;
        logic [15:0]   pqwc;
        logic          ends;
        logic          stop;
        logic          done;
        logic          irq;
    } walk_reg_t;

    walk_reg_t q, d;

    logic          stk_load, stk_push, stk_pop;
    logic [1:0]    stk_sp;
    logic [EW-1:0] stk_top, stk_push_data;
    logic          stk_full, stk_empty;

    logic [AW-1:0] dec_paddr, dec_next;
    logic          dec_pspr, dec_nspr, dec_push, dec_pop;
    logic          dec_fault, dec_ends, dec_irq;
    logic [15:0]   dec_qwc;
    logic          start_ok;

    dcw_tag_decode #(.AW(AW), .SPW(SPW)) u_decode (
        .tag       (tag_data),
        .tadr      (q.tadr),
        .tspr      (q.tspr),
        .stk_top   (stk_top),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .pkt_addr  (dec_paddr),
        .pkt_spr   (dec_pspr),
        .qwc       (dec_qwc),
        .next_tadr (dec_next),
        .next_spr  (dec_nspr),
        .push      (dec_push),
        .pop       (dec_pop),
        .push_data (stk_push_data),
        .fault     (dec_fault),
        .ends      (dec_ends),
        .irq_flag  (dec_irq)
    );

    dcw_addr_stack #(.W(EW), .DEPTH(STK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (stk_load),
        .load_sp   (ctl_wdata[5:4]),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (stk_push_data),
        .sp        (stk_sp),
        .top       (stk_top),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    assign start_ok = ctl_wdata[BIT_START] && (ctl_wdata[3:2] == MODE_CHAIN);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.irq     = 1'b0;
        stk_load  = 1'b0;
        stk_push  = 1'b0;
        stk_pop   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (ctl_wr) begin
                    stk_load = 1'b1;
                    d.ctl    = ctl_wdata;
                    d.tspr   = tadr_wspr;
                    d.tadr   = tadr_wspr ? AW'(tadr_wdata[SPW-1:0]) : tadr_wdata;
                    if (start_ok) d.st = ST_FETCH;
                    else          d.ctl[BIT_START] = 1'b0;
                end
            end
            ST_FETCH: begin
                if (tag_ack) begin
                    d.ctl[31:16] = tag_data[31:16];
                    d.cnt        = dec_qwc;
                    if (dec_fault) begin
                        d.st             = ST_IDLE;
                        d.ctl[BIT_START] = 1'b0;
                        d.done           = 1'b1;
                    end else begin
                        stk_push = dec_push;
                        stk_pop  = dec_pop;
                        d.tadr   = dec_next;
                        d.tspr   = dec_nspr;
                        d.paddr  = dec_paddr;
                        d.pspr   = dec_pspr;
                        d.pqwc   = dec_qwc;
                        d.ends   = dec_ends;
                        d.stop   = q.ctl[BIT_TIE] && dec_irq;
                        if (dec_qwc != 16'd0) begin
                            d.st = ST_ISSUE;
                        end else if (dec_ends || d.stop) begin
                            d.st             = ST_IDLE;
                            d.ctl[BIT_START] = 1'b0;
                            d.done           = 1'b1;
                            d.irq            = d.stop;
                        end
                    end
                end
            end
            ST_ISSUE: begin
                if (pkt_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (pkt_done) begin
                    if (q.ends || q.stop) begin
                        d.st             = ST_IDLE;
                        d.ctl[BIT_START] = 1'b0;
                        d.done           = 1'b1;
                        d.irq            = q.stop;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctl_rdata  = {q.ctl[31:6], stk_sp, q.ctl[3:0]};
    assign cnt_rdata  = q.cnt;
    assign tag_req    = (q.st == ST_FETCH);
    assign tag_addr   = q.tadr;
    assign tag_spr    = q.tspr;
    assign pkt_valid  = (q.st == ST_ISSUE);
    assign pkt_addr   = q.paddr;
    assign pkt_spr    = q.pspr;
    assign pkt_qwc    = q.pqwc;
    assign chain_done = q.done;
    assign chain_irq  = q.irq;
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
    parameter int AW  = 31,
    parameter int SPW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [31:0]   ctl_rdata,
    input logic          tag_req,
    input logic [AW-1:0] tag_addr,
    input logic          tag_spr,
    input logic          tag_ack,
    input logic          pkt_valid,
    input logic          pkt_ready,
    input logic [AW-1:0] pkt_addr,
    input logic          pkt_spr,
    input logic [15:0]   pkt_qwc,
    input logic          chain_done,
    input logic          chain_irq
);
    assert_pkt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_addr) && $stable(pkt_qwc) && $stable(pkt_spr));

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tag_req && !tag_ack |=> tag_req && $stable(tag_addr) && $stable(tag_spr));

    assert_req_pkt_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(tag_req && pkt_valid));

    assert_irq_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chain_irq |-> chain_done);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> !chain_done);

    assert_done_clears_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> !ctl_rdata[8]);

    assert_pkt_spr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && pkt_spr |-> (pkt_addr >> SPW) == '0);

    assert_tag_spr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tag_req && tag_spr |-> (tag_addr >> SPW) == '0);

    assert_no_empty_pkt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> pkt_qwc != 16'd0);

    assert_stack_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[5:4] != 2'd3);
endmodule

bind dma_chain_walker dcw_checker #(.AW(AW), .SPW(SPW)) u_dcw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_rdata  (ctl_rdata),
    .tag_req    (tag_req),
    .tag_addr   (tag_addr),
    .tag_spr    (tag_spr),
    .tag_ack    (tag_ack),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_addr   (pkt_addr),
    .pkt_spr    (pkt_spr),
    .pkt_qwc    (pkt_qwc),
    .chain_done (chain_done),
    .chain_irq  (chain_irq)
);

// File: tb/dma_chain_walker_tb_top.sv
module dma_chain_walker_tb_top;
    localparam int AW = 31;
    localparam int SPW = 10;
    localparam logic [63:0] END0 = 64'h00000000_70000000;
    localparam logic [31:0] GO = 32'h0000_0104;

    typedef struct packed {
        logic [63:0] tag;
        logic        tie;
        logic [30:0] e_addr;
        logic        e_spr;
        logic [15:0] e_qwc;
        logic [30:0] e_next;
        logic [3:0]  e_fetch;
        logic        e_irq;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{64'h00000000_10000003, 1'b0, 31'h11,  1'b0, 16'd3, 31'h14, 4'd2, 1'b0},
        '{64'h00000030_20000002, 1'b0, 31'h11,  1'b0, 16'd2, 31'h30, 4'd2, 1'b0},
        '{64'h00000200_30000005, 1'b0, 31'h200, 1'b0, 16'd5, 31'h11, 4'd2, 1'b0},
        '{64'h00000040_40000001, 1'b0, 31'h40,  1'b0, 16'd1, 31'h11, 4'd2, 1'b0},
        '{64'h00000050_00000004, 1'b0, 31'h50,  1'b0, 16'd4, 31'h0,  4'd1, 1'b0},
        '{64'h00000000_70000002, 1'b0, 31'h11,  1'b0, 16'd2, 31'h0,  4'd1, 1'b0},
        '{64'h00000000_90000001, 1'b1, 31'h11,  1'b0, 16'd1, 31'h0,  4'd1, 1'b1},
        '{64'h00000000_90000001, 1'b0, 31'h11,  1'b0, 16'd1, 31'h12, 4'd2, 1'b0},
        '{64'h80000005_30000002, 1'b0, 31'h5,   1'b1, 16'd2, 31'h11, 4'd2, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [31:0]   ctl_wdata = '0;
    logic [AW-1:0] tadr_wdata = '0;
    logic          tadr_wspr = 1'b0;
    logic [31:0]   ctl_rdata;
    logic [15:0]   cnt_rdata;
    logic          tag_req, tag_spr, pkt_valid, pkt_spr, chain_done, chain_irq;
    logic [AW-1:0] tag_addr, pkt_addr;
    logic [15:0]   pkt_qwc;
    logic          tag_ack = 1'b0;
    logic [63:0]   tag_data = '0;
    logic          pkt_ready = 1'b0;
    logic          pkt_done = 1'b0;

    logic [63:0]   mem [1024];
    logic [30:0]   f_addr [8];
    logic          f_spr [8];
    logic [30:0]   p_addr [8];
    logic          p_spr [8];
    logic [15:0]   p_qwc [8];
    int f_n = 0, p_n = 0, done_n = 0, irq_n = 0, overlap_n = 0, wait_cnt = 0;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dma_chain_walker #(.AW(AW), .SPW(SPW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .tadr_wdata(tadr_wdata), .tadr_wspr(tadr_wspr), .ctl_rdata(ctl_rdata),
        .cnt_rdata(cnt_rdata), .tag_req(tag_req), .tag_addr(tag_addr), .tag_spr(tag_spr),
        .tag_ack(tag_ack), .tag_data(tag_data), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_addr(pkt_addr), .pkt_spr(pkt_spr), .pkt_qwc(pkt_qwc), .pkt_done(pkt_done),
        .chain_done(chain_done), .chain_irq(chain_irq)
    );

    // Memory responder, data mover model and monitors
    initial begin
        forever begin
            @(negedge clk);
            if (tag_req && pkt_valid) overlap_n++;
            if (chain_done) done_n++;
            if (chain_irq) irq_n++;
            if (tag_req && !tag_ack) begin
                tag_ack = 1'b1;
                tag_data = mem[tag_addr[9:0]];
                if (f_n < 8) begin f_addr[f_n] = tag_addr; f_spr[f_n] = tag_spr; end
                f_n++;
            end else begin
                tag_ack = 1'b0;
            end
            pkt_done = 1'b0;
            if (wait_cnt != 0) begin
                wait_cnt--;
                if (wait_cnt == 0) pkt_done = 1'b1;
            end
            if (pkt_ready) begin
                pkt_ready = 1'b0;
                wait_cnt = 2;
            end else if (pkt_valid) begin
                if (p_n < 8) begin p_addr[p_n] = pkt_addr; p_spr[p_n] = pkt_spr; p_qwc[p_n] = pkt_qwc; end
                p_n++;
                pkt_ready = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic prep();
        @(posedge clk);
        for (int i = 0; i < 1024; i++) mem[i] = END0;
        f_n = 0; p_n = 0; done_n = 0; irq_n = 0;
    endtask

    task automatic start(input logic [31:0] w, input logic [30:0] a, input logic s);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = w; tadr_wdata = a; tadr_wspr = s;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400; i++) begin
            @(posedge clk);
            if (done_n != 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ctl_rdata == 0 && !tag_req && !pkt_valid && !chain_done, "R1 reset", ctl_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table: one tag at 0x10, followed by terminating zero-count tags
        for (int v = 0; v < 9; v++) begin
            prep();
            mem[16] = VECS[v].tag;
            start(GO | (VECS[v].tie ? 32'h80 : 32'h0), 31'h10, 1'b0);
            wait_done();
            chk(p_n == 1, "R11 packet count", p_n, 1);
            chk(p_addr[0] == VECS[v].e_addr && p_spr[0] == VECS[v].e_spr, "R3/R4 packet source",
                {p_spr[0], p_addr[0]}, {VECS[v].e_spr, VECS[v].e_addr});
            chk(p_qwc[0] == VECS[v].e_qwc, "R3 packet count", p_qwc[0], VECS[v].e_qwc);
            chk(f_n == int'(VECS[v].e_fetch), "R6 fetch count", f_n, VECS[v].e_fetch);
            if (VECS[v].e_fetch == 4'd2)
                chk(f_addr[1] == VECS[v].e_next, "R5 next tag address", f_addr[1], VECS[v].e_next);
            chk(irq_n == int'(VECS[v].e_irq) && done_n == 1, "R9 irq/done",
                {irq_n[7:0], done_n[7:0]}, {7'd0, VECS[v].e_irq, 8'd1});
            chk(ctl_rdata[8] == 1'b0, "R6 start cleared", ctl_rdata[8], 0);
        end

        // R2 mirror of tag upper half and count
        prep();
        mem[16] = 64'h00000050_0C000004;
        start(GO, 31'h10, 1'b0);
        wait_done();
        chk(ctl_rdata[31:16] == 16'h0C00, "R2 mirror", ctl_rdata[31:16], 16'h0C00);
        chk(cnt_rdata == 16'd4, "R2 count", cnt_rdata, 4);

        // R7 call and return
        prep();
        mem[16] = 64'h00000040_50000002;
        mem[64] = 64'h00000000_60000001;
        start(GO, 31'h10, 1'b0);
        chk(ctl_rdata[8] == 1'b1, "R1 start held while running", ctl_rdata[8], 1);
        wait_done();
        chk(f_n == 3 && f_addr[1] == 31'h40 && f_addr[2] == 31'h13, "R7 fetch path",
            {f_addr[1], f_addr[2]}, {31'h40, 31'h13});
        chk(p_n == 2 && p_addr[1] == 31'h41, "R7 ret data", p_addr[1], 31'h41);
        chk(ctl_rdata[5:4] == 2'd0, "R7 stack depth", ctl_rdata[5:4], 0);

        // R8 stack overflow
        prep();
        mem[16] = 64'h00000040_50000002;
        start(GO | 32'h20, 31'h10, 1'b0);
        wait_done();
        chk(p_n == 0 && f_n == 1 && done_n == 1, "R8 overflow ends", p_n, 0);
        chk(ctl_rdata[5:4] == 2'd2, "R8 depth kept", ctl_rdata[5:4], 2);

        // R8 stack underflow
        prep();
        mem[16] = 64'h00000000_60000001;
        start(GO, 31'h10, 1'b0);
        wait_done();
        chk(p_n == 0 && f_n == 1 && done_n == 1, "R8 underflow ends", p_n, 0);

        // R7 written depth 3 clamps to 2
        prep();
        start(32'h0000_0030, 31'h10, 1'b0);
        chk(ctl_rdata[5:4] == 2'd2, "R7 depth clamp", ctl_rdata[5:4], 2);

        // R10 scratchpad wrap
        prep();
        mem[1023] = 64'h00000000_10000002;
        start(GO, 31'h3FF, 1'b1);
        wait_done();
        chk(p_addr[0] == 31'h0 && p_spr[0], "R10 data wrap", p_addr[0], 0);
        chk(f_n == 2 && f_addr[1] == 31'h2 && f_spr[1], "R10 next wrap", f_addr[1], 2);

        // R11 zero-count tag
        prep();
        mem[16] = 64'h00000000_10000000;
        start(GO, 31'h10, 1'b0);
        wait_done();
        chk(p_n == 0 && f_n == 2 && f_addr[1] == 31'h11, "R11 zero count", f_addr[1], 31'h11);

        // R1 start in non-chain mode is ignored
        prep();
        start(32'h0000_0100, 31'h10, 1'b0);
        repeat (20) @(negedge clk);
        chk(f_n == 0 && ctl_rdata[8] == 1'b0, "R1 non-chain start", f_n, 0);

        // R1 write while running is ignored
        prep();
        mem[16] = 64'h00000000_10000003;
        start(GO, 31'h10, 1'b0);
        ctl_wr = 1'b1; ctl_wdata = 32'h0; tadr_wdata = 31'h77;
        @(negedge clk);
        ctl_wr = 1'b0;
        wait_done();
        chk(p_n == 1 && f_n == 2 && f_addr[1] == 31'h14, "R1 busy write", f_addr[1], 31'h14);

        chk(overlap_n == 0, "R12 request/packet overlap", overlap_n, 0);
        summary();
    end
endmodule